// File: doc/BRIEF.md
# Circular Sample Buffer Interrupt Unit

This block follows the position of a circular buffer that a sample engine fills or drains, one slot per sample. It also gathers the other conditions of a serial sample port that need software attention. Every accepted sample pulses an advance strobe. The unit keeps a fill pointer against a programmable buffer length and raises events when the pointer reaches half of the buffer, when it reaches the full length, and on every step. These events share one set of eight sticky status flags with five other conditions:

- a bus error seen by the sample engine,
- two holding-register-ready signals,
- a data over/underrun error,
- a serial-clock activity wakeup that is brought in asynchronously.

An 8-bit enable register masks the flags. A single interrupt line is the OR of the flags that are both set and enabled.

Software reaches both registers through a plain register port. One select bit chooses the status register or the enable register. Reads are combinational. The port accepts a write in every cycle and exerts no back-pressure. Writes to the enable register store the value. Writes to the status register clear each flag whose data bit is 1, and leave the other flags as they are. No data stream crosses the block's boundary, so no valid/ready handshake is used; all pins are plain control and status signals.

Top module: `bufptr_irq_unit`

## Requirements
- R1: After reset the status flags, the enable register, the fill pointer and the interrupt line are all zero.
- R2: Each cycle with the advance strobe high moves the fill pointer up by one while it is below the programmed length. An advance taken with the pointer at or above the length sets it to 1, because the pointer wraps to zero and counts the new sample. A cycle without the strobe leaves the pointer unchanged. The length must be even and at least 2.
- R3: Status bit 1 (half) is set by the advance that brings the pointer to length/2.
- R4: Status bit 2 (end) is set by the advance that brings the pointer to the length.
- R5: Status bit 3 (step) is set on each 0-to-1 transition of the advance strobe.
- R6: On a 0-to-1 transition of the corresponding input, the following status bits are set one clock edge later: bit 0 for bus error, bit 4 for ready A, bit 5 for ready B and bit 7 for data error.
- R7: The clock-activity input passes through a two-flop synchronizer and a rising-edge detector. A rise that is stable before clock edge 1 sets status bit 6 at edge 3 and not earlier.
- R8: Status flags are sticky. A write with select 0 clears exactly the flags whose data bits are 1. Data bits that are 0 leave their flags unchanged.
- R9: If a flag is set and cleared in the same cycle, the set wins.
- R10: A write with select 1 loads the enable register. A read returns the status register when select is 0 and the enable register when select is 1.
- R11: The interrupt line is high exactly when some status bit and its enable bit are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| adv_i | input | 1 | One-cycle strobe per sample moved through the buffer |
| buf_len_i | input | LEN_W | Buffer length in samples (even, at least 2) |
| bus_err_i | input | 1 | Bus error from the sample engine |
| rdy_a_i | input | 1 | Holding register A ready |
| rdy_b_i | input | 1 | Holding register B ready |
| data_err_i | input | 1 | Holding register overrun/underrun |
| clk_act_i | input | 1 | Asynchronous serial-clock activity indication |
| reg_sel_i | input | 1 | Register select: 0 status, 1 enable |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data of the selected register |
| buf_ptr_o | output | LEN_W | Current fill pointer |
| irq_o | output | 1 | Combined interrupt |

## Verification
The bench builds the unit with LEN_W = 4, so the pointer spans 0 to 15. It sweeps every legal even length from 2 to 14, taking more than two full laps per length, and checks each pointer value and each half, end and step flag against an arithmetic model. It sweeps all 256 enable values with every flag pending and also walks one-hot enables. The bench also exercises the set-versus-clear collision and the exact edge at which the synchronized activity flag appears.

// File: rtl/bpi_pkg.sv
package bpi_pkg;
  localparam int unsigned NUM_SRC = 8;

  // bit positions in the status and enable registers
  localparam int unsigned B_BUSERR = 0;
  localparam int unsigned B_HALF   = 1;
  localparam int unsigned B_END    = 2;
  localparam int unsigned B_STEP   = 3;
  localparam int unsigned B_RDYA   = 4;
  localparam int unsigned B_RDYB   = 5;
  localparam int unsigned B_ACT    = 6;
  localparam int unsigned B_DERR   = 7;

  typedef logic [NUM_SRC-1:0] src_vec_t;

  typedef enum logic {
    SEL_STATUS = 1'b0,
    SEL_ENABLE = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/bpi_fill_ptr.sv
module bpi_fill_ptr #(
  parameter int unsigned LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv_i,
  input  logic [LEN_W-1:0] len_i,
  output logic [LEN_W-1:0] ptr_o,
  output logic             half_o,
  output logic             end_o,
  output logic             step_o
);
  localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

  logic [LEN_W-1:0] ptr_q;
  logic [LEN_W-1:0] ptr_nxt;
  logic             at_end;

  assign at_end  = (ptr_q >= len_i);
  assign ptr_nxt = at_end ? ONE : (ptr_q + ONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ptr_q <= '0;
    else if (adv_i) ptr_q <= ptr_nxt;
  end

  assign half_o = adv_i && (ptr_nxt == (len_i >> 1));
  assign end_o  = adv_i && (ptr_nxt == len_i);
  assign step_o = adv_i;
  assign ptr_o  = ptr_q;

  // R2
  ptr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_i && ptr_q >= len_i) |=> (ptr_q == ONE));
  // R2
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_i && ptr_q < len_i) |=> (ptr_q == $past(ptr_q) + ONE));
  // R2
  ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !adv_i |=> $stable(ptr_q));
endmodule

// File: rtl/bpi_sync_edge.sv
module bpi_sync_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic pulse_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[g] <= 1'b0;
          else        sync_q[g] <= async_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[g] <= 1'b0;
          else        sync_q[g] <= sync_q[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= sync_q[STAGES-1];
  end

  assign pulse_o = sync_q[STAGES-1] & ~prev_q;

  // R7
  act_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_o |=> !pulse_o);
endmodule

// File: rtl/bpi_status_regs.sv
module bpi_status_regs
  import bpi_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  src_vec_t ev_i,
  input  logic     wr_i,
  input  logic     sel_i,
  input  src_vec_t wdata_i,
  output src_vec_t rdata_o,
  output logic     irq_o
);
  src_vec_t ev_q, stat_q, en_q, rise, clr;

  assign rise = ev_i & ~ev_q;
  assign clr  = (wr_i && (sel_i == SEL_STATUS)) ? wdata_i : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ev_q   <= '0;
      stat_q <= '0;
      en_q   <= '0;
    end else begin
      ev_q   <= ev_i;
      stat_q <= (stat_q & ~clr) | rise;
      if (wr_i && (sel_i == SEL_ENABLE)) en_q <= wdata_i;
    end
  end

  assign rdata_o = (sel_i == SEL_ENABLE) ? en_q : stat_q;
  assign irq_o   = |(stat_q & en_q);

  generate
    for (genvar b = 0; b < NUM_SRC; b++) begin : g_bit_chk
      // R9
      set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise[b] |=> stat_q[b]);
      // R8
      sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_q[b] && !clr[b]) |=> stat_q[b]);
      // R8
      w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr[b] && !rise[b]) |=> !stat_q[b]);
    end
  endgenerate
endmodule

// File: rtl/bufptr_irq_unit.sv
module bufptr_irq_unit
  import bpi_pkg::*;
#(
  parameter int unsigned LEN_W       = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv_i,
  input  logic [LEN_W-1:0] buf_len_i,
  input  logic             bus_err_i,
  input  logic             rdy_a_i,
  input  logic             rdy_b_i,
  input  logic             data_err_i,
  input  logic             clk_act_i,
  input  logic             reg_sel_i,
  input  logic             reg_wr_i,
  input  logic [7:0]       reg_wdata_i,
  output logic [7:0]       reg_rdata_o,
  output logic [LEN_W-1:0] buf_ptr_o,
  output logic             irq_o
);
  logic     half_ev, end_ev, step_ev, act_ev;
  src_vec_t ev;

  bpi_fill_ptr #(.LEN_W(LEN_W)) u_ptr (
    .clk    (clk),
    .rst_n  (rst_n),
    .adv_i  (adv_i),
    .len_i  (buf_len_i),
    .ptr_o  (buf_ptr_o),
    .half_o (half_ev),
    .end_o  (end_ev),
    .step_o (step_ev)
  );

  bpi_sync_edge #(.STAGES(SYNC_STAGES)) u_act (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (clk_act_i),
    .pulse_o (act_ev)
  );

  always_comb begin
    ev           = '0;
    ev[B_BUSERR] = bus_err_i;
    ev[B_HALF]   = half_ev;
    ev[B_END]    = end_ev;
    ev[B_STEP]   = step_ev;
    ev[B_RDYA]   = rdy_a_i;
    ev[B_RDYB]   = rdy_b_i;
    ev[B_ACT]    = act_ev;
    ev[B_DERR]   = data_err_i;
  end

  bpi_status_regs u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .ev_i    (ev),
    .wr_i    (reg_wr_i),
    .sel_i   (reg_sel_i),
    .wdata_i (reg_wdata_i),
    .rdata_o (reg_rdata_o),
    .irq_o   (irq_o)
  );

  // R11
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_sel_i == SEL_STATUS && reg_rdata_o == 8'h00) |-> !irq_o);
endmodule

// File: tb/test_bufptr_irq_unit.sv
`timescale 1ns/1ps
module test_bufptr_irq_unit;
  localparam int unsigned LW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          adv = 1'b0;
  logic [LW-1:0] len = LW'(2);
  logic          buserr = 1'b0, rdya = 1'b0, rdyb = 1'b0, derr = 1'b0, act = 1'b0;
  logic          sel = 1'b0, wr = 1'b0;
  logic [7:0]    wdata = 8'h00;
  logic [7:0]    rdata;
  logic [LW-1:0] ptr;
  logic          irq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  bufptr_irq_unit #(.LEN_W(LW)) i_bufptr_irq_unit (
    .clk(clk), .rst_n(rst_n), .adv_i(adv), .buf_len_i(len),
    .bus_err_i(buserr), .rdy_a_i(rdya), .rdy_b_i(rdyb), .data_err_i(derr),
    .clk_act_i(act), .reg_sel_i(sel), .reg_wr_i(wr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .buf_ptr_o(ptr), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [31:0] actv, input logic [31:0] expv);
    n_chk++;
    if (actv !== expv) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, actv, expv);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  task automatic reg_write(input logic s, input logic [7:0] d);
    @(negedge clk); sel = s; wr = 1'b1; wdata = d;
    @(negedge clk); wr = 1'b0; sel = 1'b0;
  endtask

  task automatic read_status(output logic [7:0] v);
    sel = 1'b0; #0.1; v = rdata;
  endtask

  task automatic advance();
    @(negedge clk); adv = 1'b1;
    @(negedge clk); adv = 1'b0;
  endtask

  task automatic pulse_in(input int which);
    @(negedge clk);
    case (which)
      0: buserr = 1'b1;
      4: rdya = 1'b1;
      5: rdyb = 1'b1;
      default: derr = 1'b1;
    endcase
    @(negedge clk);
    buserr = 1'b0; rdya = 1'b0; rdyb = 1'b0; derr = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [7:0] st;
    int e;
    repeat (3) @(negedge clk);
    // R1 reset state
    read_status(st);
    chk("R1 status", st, 8'h00);
    chk("R1 ptr", ptr, 0);
    chk("R1 irq", irq, 0);
    sel = 1'b1; #0.1; chk("R1 enable", rdata, 8'h00); sel = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);

    // R2 R3 R4 R5 pointer sweep over every legal length
    for (int L = 2; L <= 14; L += 2) begin
      len = LW'(L);
      reg_write(1'b0, 8'hFF);
      e = ptr;
      for (int k = 0; k < 2 * L + 1; k++) begin
        logic [7:0] exp_st;
        e = (e >= L) ? 1 : e + 1;
        advance();
        chk("R2 pointer", ptr, e);
        read_status(st);
        exp_st = 8'h08;
        if (e == L / 2) exp_st[1] = 1'b1;
        if (e == L)     exp_st[2] = 1'b1;
        chk("R3 R4 R5 status after advance", st, exp_st);
        reg_write(1'b0, 8'hFF);
        read_status(st);
        chk("R8 clear all", st, 8'h00);
      end
      // R2 no advance holds the pointer
      repeat (3) @(negedge clk);
      chk("R2 hold", ptr, e);
    end

    // R6 single-source edges land on their own bits
    pulse_in(0); read_status(st); chk("R6 bus error bit0", st, 8'h01);
    pulse_in(4); read_status(st); chk("R6 ready A bit4", st, 8'h11);
    pulse_in(5); read_status(st); chk("R6 ready B bit5", st, 8'h31);
    pulse_in(7); read_status(st); chk("R6 data error bit7", st, 8'hB1);
    // R8 writing zeros changes nothing, a single one clears one bit
    reg_write(1'b0, 8'h00); read_status(st); chk("R8 zero write", st, 8'hB1);
    reg_write(1'b0, 8'h10); read_status(st); chk("R8 single clear", st, 8'hA1);
    // R6 a held level sets once: after clear it stays clear
    @(negedge clk); rdya = 1'b1;
    @(negedge clk); reg_write(1'b0, 8'h10);
    read_status(st); chk("R6 level sets once", st, 8'hA1);
    rdya = 1'b0;

    // R9 set and clear of bit0 in the same cycle
    @(negedge clk); buserr = 1'b1; sel = 1'b0; wr = 1'b1; wdata = 8'h01;
    @(negedge clk); wr = 1'b0; buserr = 1'b0;
    read_status(st); chk("R9 set wins", st[0], 1'b1);
    reg_write(1'b0, 8'h01); read_status(st); chk("R9 later clear", st[0], 1'b0);
    reg_write(1'b0, 8'hFF);

    // R7 activity synchronizer latency
    @(negedge clk); act = 1'b1;
    @(negedge clk); read_status(st); chk("R7 after edge 1", st[6], 1'b0);
    @(negedge clk); read_status(st); chk("R7 after edge 2", st[6], 1'b0);
    @(negedge clk); read_status(st); chk("R7 after edge 3", st[6], 1'b1);
    reg_write(1'b0, 8'h40);
    repeat (3) @(negedge clk);
    read_status(st); chk("R7 steady high no new event", st[6], 1'b0);
    act = 1'b0;
    repeat (4) @(negedge clk);

    // set all eight flags for the mask sweep
    len = LW'(2);
    advance();
    if (ptr != 2) advance();
    pulse_in(0); pulse_in(4); pulse_in(5); pulse_in(7);
    @(negedge clk); act = 1'b1; repeat (4) @(negedge clk); act = 1'b0;
    read_status(st); chk("R6 R7 all pending", st, 8'hFF);

    // R10 R11 every enable value with all flags pending
    for (int m = 0; m < 256; m++) begin
      reg_write(1'b1, 8'(m));
      sel = 1'b1; #0.1; chk("R10 enable readback", rdata, m); sel = 1'b0; #0.1;
      chk("R11 irq all pending", irq, (m != 0));
    end
    // R11 one-hot enables against a shrinking status
    for (int b = 0; b < 8; b++) begin
      reg_write(1'b1, 8'(1 << b));
      #0.1; chk("R11 enabled pending", irq, 1'b1);
      reg_write(1'b0, 8'(1 << b));
      #0.1; chk("R11 enabled cleared", irq, 1'b0);
    end
    read_status(st); chk("R8 all cleared", st, 8'h00);

    summary();
  end
endmodule